// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Selectable Parity

This block takes one asynchronous serial line and turns each frame on it into a parallel byte. A base clock drives all of its logic. An external divider supplies a baud tick at sixteen times the bit rate. The line passes through a resynchronizer first. The receiver then waits for a falling edge and confirms the start bit half a bit later. After that it samples every following bit at its centre: eight data bits, least significant first, then a parity bit if the mode calls for one, then one stop bit.

When the stop bit has been sampled, the byte goes into a holding register. In that same cycle a one-cycle completion pulse fires. A two-bit parity mode selects one of four treatments of the parity bit. A parity mismatch or a low stop bit sets a status flag and fires a one-cycle error pulse together with the completion pulse.

Dropping the receive enable resets the receiver synchronously. Any frame in progress is abandoned, and the held byte is kept. The parity mode can only be rewritten while both the receive enable and the transmit enable are low.

Top module: `srx_receiver`

## Requirements
- R1: While `rx_en` is low, line activity produces no `rx_done` pulse and `rx_data` keeps its previous value.
- R2: With `rx_en` low, the receiver returns to idle on the next clock edge and clears `par_err` and `frm_err`, but keeps `rx_data`. After reset every output is 0.
- R3: A low level on the line is accepted as a start bit only if the line is still low at the middle of the start bit. If it is high at that point, the receiver goes back to idle and produces no frame.
- R4: Each bit lasts 16 baud ticks. Data is 8 bits, least significant bit first. A parity bit follows only when the mode is not 00, and one stop bit ends the frame.
- R5: `rx_data` changes only on the clock edge that raises `rx_done`. `rx_done` is a single-cycle pulse, and the new byte is visible in that same cycle.
- R6: Parity mode encoding: 00 means no parity bit, 01 means a parity bit that is read but never checked, 10 means odd, 11 means even. In odd mode, an even count of ones over the data bits and the parity bit sets `par_err`. In even mode, an odd count sets it.
- R7: In mode 01 the parity bit is consumed and ignored. `par_err` stays 0 whatever the value of that bit, and no error pulse comes from parity.
- R8: A stop bit sampled low sets `frm_err`. The byte is still transferred and `rx_done` still pulses.
- R9: A write on `pmode_wr` takes effect only when `rx_en` and `tx_en` are both low. Otherwise it is ignored.
- R10: `err_irq` pulses only together with `rx_done`, and exactly when that frame has a parity or framing fault. `par_err` and `frm_err` are rewritten at each completion, so a clean frame clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Receive enable; low resets the receive logic synchronously |
| tx_en | input | 1 | Transmit enable; used only to lock the parity mode |
| pmode_wr | input | 1 | Write strobe for the parity mode |
| pmode_wdata | input | 2 | New parity mode (00 none, 01 unchecked, 10 odd, 11 even) |
| rxd | input | 1 | Serial line, idle high |
| rx_data | output | 8 | Holding register with the last received byte |
| rx_done | output | 1 | Completion pulse, one cycle |
| par_err | output | 1 | Parity fault of the last frame |
| frm_err | output | 1 | Stop-bit fault of the last frame |
| err_irq | output | 1 | Error pulse, one cycle, coincident with `rx_done` |

## Verification
The completion pulse and the error pulse share a cycle whenever a frame is faulty. The bench provokes this with frames that carry a deliberately inverted parity bit, a low stop bit, or both. A monitor running on the falling edge records the byte, both flags and `err_irq` in the exact cycle `rx_done` is high. It also counts every `err_irq` pulse on its own, so an error pulse that arrives a cycle early or late, or without a completion, breaks the count. The error outcome the bench expects comes from its own parity function, which uses the mode and the bits it sent.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4
  } srx_state_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'b00,
    PM_ZERO = 2'b01,
    PM_ODD  = 2'b10,
    PM_EVEN = 2'b11
  } pmode_e;

  // data_xor is the XOR reduction of the data bits; pbit is the received parity bit
  function automatic logic parity_fault(pmode_e m, logic data_xor, logic pbit);
    logic ones_odd;
    ones_odd = data_xor ^ pbit;
    case (m)
      PM_ODD:  parity_fault = !ones_odd;
      PM_EVEN: parity_fault = ones_odd;
      default: parity_fault = 1'b0;
    endcase
  endfunction

  function automatic logic mode_has_pbit(pmode_e m);
    mode_has_pbit = (m != PM_NONE);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_mode_reg.sv
module srx_mode_reg
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       rx_en,
  input  logic       tx_en,
  output pmode_e     mode
);
  logic wr_ok;
  assign wr_ok = wr && !rx_en && !tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode <= PM_NONE;
    else if (wr_ok) mode <= pmode_e'(wdata);
  end
endmodule

// File: rtl/srx_tick_ctr.sv
module srx_tick_ctr #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic mid_hit,
  output logic bit_end
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign mid_hit = tick && (cnt == MID);
  assign bit_end = tick && (cnt == LAST);
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          tick,
  input  logic          rxs,
  input  logic          mid_hit,
  input  logic          bit_end,
  input  pmode_e        mode,
  output logic          ctr_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_done,
  output logic          par_err,
  output logic          frm_err,
  output logic          err_irq,
  output logic          fsm_idle,
  output logic          ev_start_ok,
  output logic          ev_false_start
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  srx_state_e    state;
  logic [DW-1:0] shreg;
  logic [BW-1:0] bitn;
  logic          pbit_q;
  logic          pf;
  logic          stop_bad;

  assign fsm_idle       = (state == S_IDLE);
  assign ev_start_ok    = rx_en && (state == S_START) && mid_hit && !rxs;
  assign ev_false_start = rx_en && (state == S_START) && mid_hit && rxs;
  assign ctr_clr        = !rx_en || fsm_idle || (state == S_START && mid_hit);
  assign pf             = parity_fault(mode, ^shreg, pbit_q);
  assign stop_bad       = !rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      shreg   <= '0;
      bitn    <= '0;
      pbit_q  <= 1'b0;
      rx_data <= '0;
      rx_done <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      err_irq <= 1'b0;
      if (!rx_en) begin
        state   <= S_IDLE;
        bitn    <= '0;
        par_err <= 1'b0;
        frm_err <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (tick && !rxs) state <= S_START;
          S_START: begin
            if (ev_start_ok) begin
              state <= S_DATA;
              bitn  <= '0;
            end else if (ev_false_start) begin
              state <= S_IDLE;
            end
          end
          S_DATA: begin
            if (bit_end) begin
              shreg <= {rxs, shreg[DW-1:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == LAST_BIT)
                state <= mode_has_pbit(mode) ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            if (bit_end) begin
              pbit_q <= rxs;
              state  <= S_STOP;
            end
          end
          S_STOP: begin
            if (bit_end) begin
              rx_data <= shreg;
              rx_done <= 1'b1;
              par_err <= pf;
              frm_err <= stop_bad;
              err_irq <= pf || stop_bad;
              state   <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
  import srx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 rx_en,
  input  logic                 tx_en,
  input  logic                 pmode_wr,
  input  logic [1:0]           pmode_wdata,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_done,
  output logic                 par_err,
  output logic                 frm_err,
  output logic                 err_irq
);
  pmode_e mode_q;
  logic   rxs;
  logic   ctr_clr;
  logic   mid_hit;
  logic   bit_end;
  logic   fsm_idle;
  logic   ev_start_ok;
  logic   ev_false_start;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs)
  );

  srx_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr(pmode_wr), .wdata(pmode_wdata),
    .rx_en(rx_en), .tx_en(tx_en), .mode(mode_q)
  );

  srx_tick_ctr #(.OSR(OSR)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .tick(baud_tick),
    .mid_hit(mid_hit), .bit_end(bit_end)
  );

  srx_frame_fsm #(.DW(DATA_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(baud_tick), .rxs(rxs),
    .mid_hit(mid_hit), .bit_end(bit_end), .mode(mode_q), .ctr_clr(ctr_clr),
    .rx_data(rx_data), .rx_done(rx_done), .par_err(par_err), .frm_err(frm_err),
    .err_irq(err_irq), .fsm_idle(fsm_idle), .ev_start_ok(ev_start_ok),
    .ev_false_start(ev_false_start)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          tx_en,
  input logic [1:0]    mode,
  input logic [DW-1:0] rx_data,
  input logic          rx_done,
  input logic          par_err,
  input logic          frm_err,
  input logic          err_irq,
  input logic          fsm_idle,
  input logic          ev_false_start
);
  a_r1_off_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_done);

  a_r2_off_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (fsm_idle && !par_err && !frm_err));

  a_r3_false_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_false_start |=> fsm_idle);

  a_r5_data_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_done);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  a_r7_no_check_no_parerr: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 || mode == 2'b00) |-> !par_err);

  a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en || tx_en) |=> $stable(mode));

  a_r10_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> rx_done);
endmodule

bind srx_receiver srx_checker #(.DW(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en), .mode(mode_q),
  .rx_data(rx_data), .rx_done(rx_done), .par_err(par_err), .frm_err(frm_err),
  .err_irq(err_irq), .fsm_idle(fsm_idle), .ev_false_start(ev_false_start)
);

// File: tb/srx_receiver_tb_top.sv
module srx_receiver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_en = 1'b0;
  logic       tx_en = 1'b0;
  logic       pmode_wr = 1'b0;
  logic [1:0] pmode_wdata = 2'b00;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_done, par_err, frm_err, err_irq;

  int checks = 0, fails = 0, cyc = 0;
  int done_cnt = 0, irq_cnt = 0;
  logic [7:0] cap_data;
  logic cap_pe, cap_fe, cap_irq;
  int tdiv = 0;

  srx_receiver dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en), .tx_en(tx_en),
    .pmode_wr(pmode_wr), .pmode_wdata(pmode_wdata), .rxd(rxd), .rx_data(rx_data),
    .rx_done(rx_done), .par_err(par_err), .frm_err(frm_err), .err_irq(err_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv      <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV-1);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_done) begin
        done_cnt++;
        cap_data = rx_data;
        cap_pe   = par_err;
        cap_fe   = frm_err;
        cap_irq  = err_irq;
      end
      if (err_irq) irq_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic exp_fault(logic [1:0] m, logic [7:0] d, logic pb);
    logic cnt_odd;
    cnt_odd = 1'b0;
    for (int i = 0; i < 8; i++) cnt_odd = cnt_odd ^ d[i];
    cnt_odd = cnt_odd ^ pb;
    if (m == 2'b10) return (cnt_odd == 1'b0);
    if (m == 2'b11) return (cnt_odd == 1'b1);
    return 1'b0;
  endfunction

  function automatic logic good_pbit(logic [1:0] m, logic [7:0] d);
    logic x;
    x = ^d;
    return (m == 2'b10) ? ~x : x;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!baud_tick);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); rx_en = 1'b0; tx_en = 1'b0;
    pmode_wr = 1'b1; pmode_wdata = m;
    @(negedge clk); pmode_wr = 1'b0;
    repeat (2) @(negedge clk);
    rx_en = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] m,
                            input logic pb, input logic stopv);
    rxd = 1'b0; wait_ticks(16);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_ticks(16); end
    if (m != 2'b00) begin rxd = pb; wait_ticks(16); end
    rxd = stopv;
    wait_ticks(stopv ? 16 : 10);
    rxd = 1'b1;
    wait_ticks(20);
  endtask

  task automatic frame_check(input logic [7:0] d, input logic [1:0] m,
                             input logic pb, input logic stopv, input string tag);
    int d0, i0;
    logic pe, fe;
    d0 = done_cnt; i0 = irq_cnt;
    pe = exp_fault(m, d, pb);
    fe = !stopv;
    send_frame(d, m, pb, stopv);
    chk(done_cnt == d0 + 1, {tag, " R5 one completion"}, done_cnt - d0, 1);
    chk(cap_data == d, {tag, " R4 R5 byte at completion"}, cap_data, d);
    chk(cap_pe == pe, {tag, " R6 R7 R10 parity flag"}, cap_pe, pe);
    chk(cap_fe == fe, {tag, " R8 R10 framing flag"}, cap_fe, fe);
    chk(cap_irq == (pe | fe), {tag, " R10 err pulse with done"}, cap_irq, pe | fe);
    chk(irq_cnt == i0 + int'(pe | fe), {tag, " R10 err pulse count"}, irq_cnt - i0, int'(pe | fe));
  endtask

  initial begin
    logic [7:0] held;
    int d0;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_data == 8'h00 && !rx_done && !par_err && !frm_err && !err_irq,
        "R2 reset state", {rx_data, rx_done, par_err, frm_err, err_irq}, 0);
    rx_en = 1'b1;
    wait_ticks(20);

    // R4 plain frames, mode 00
    frame_check(8'hA5, 2'b00, 1'b0, 1'b1, "none A5");
    frame_check(8'h01, 2'b00, 1'b0, 1'b1, "none 01");
    // R8 low stop bit, then R10 clean frame clears flags
    frame_check(8'h3C, 2'b00, 1'b0, 1'b0, "none bad stop");
    frame_check(8'hC3, 2'b00, 1'b0, 1'b1, "none clean after fault");

    // R6 odd and even parity
    set_mode(2'b10);
    frame_check(8'h7E, 2'b10, good_pbit(2'b10, 8'h7E), 1'b1, "odd good");
    frame_check(8'h7E, 2'b10, ~good_pbit(2'b10, 8'h7E), 1'b1, "odd bad");
    set_mode(2'b11);
    frame_check(8'h81, 2'b11, good_pbit(2'b11, 8'h81), 1'b1, "even good");
    frame_check(8'h80, 2'b11, ~good_pbit(2'b11, 8'h80), 1'b0, "even bad both");

    // R7 zero-parity mode: both parity bit values accepted
    set_mode(2'b01);
    frame_check(8'h55, 2'b01, 1'b1, 1'b1, "zero pb1");
    frame_check(8'h55, 2'b01, 1'b0, 1'b1, "zero pb0");

    // R9 ignored writes: mode stays even, bad parity must be flagged
    set_mode(2'b11);
    @(negedge clk); rx_en = 1'b0; tx_en = 1'b1; pmode_wr = 1'b1; pmode_wdata = 2'b00;
    @(negedge clk); pmode_wr = 1'b0; tx_en = 1'b0; rx_en = 1'b1;
    @(negedge clk); pmode_wr = 1'b1; pmode_wdata = 2'b00;
    @(negedge clk); pmode_wr = 1'b0;
    frame_check(8'h0F, 2'b11, 1'b1, 1'b1, "R9 write ignored");

    // R3 short glitch is not a start bit
    d0 = done_cnt;
    rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(40);
    chk(done_cnt == d0, "R3 glitch no frame", done_cnt - d0, 0);
    frame_check(8'h99, 2'b11, good_pbit(2'b11, 8'h99), 1'b1, "R3 frame after glitch");

    // R1 disabled reception
    held = rx_data;
    d0 = done_cnt;
    @(negedge clk); rx_en = 1'b0;
    send_frame(8'h12, 2'b11, 1'b0, 1'b1);
    chk(done_cnt == d0, "R1 no completion while off", done_cnt - d0, 0);
    chk(rx_data == held, "R1 byte held while off", rx_data, held);
    rx_en = 1'b1;
    wait_ticks(4);

    // R2 abort mid-frame after a fault left flags set
    set_mode(2'b00);
    frame_check(8'hE7, 2'b00, 1'b0, 1'b0, "R2 prep fault");
    held = rx_data;
    d0 = done_cnt;
    rxd = 1'b0; wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      if (i == 4) begin @(negedge clk); rx_en = 1'b0; end
      rxd = i[0]; wait_ticks(16);
    end
    rxd = 1'b1; wait_ticks(20);
    chk(done_cnt == d0, "R2 aborted frame no completion", done_cnt - d0, 0);
    chk(rx_data == held, "R2 byte kept after abort", rx_data, held);
    chk(!par_err && !frm_err, "R2 flags cleared", {par_err, frm_err}, 0);
    rx_en = 1'b1;
    wait_ticks(4);

    // random frames
    for (int n = 0; n < 24; n++) begin
      logic [1:0] m;
      logic [7:0] d;
      logic pb, st;
      m  = 2'($urandom_range(0, 3));
      d  = 8'($urandom);
      st = ($urandom_range(0, 4) != 0);
      if (m == 2'b01) pb = 1'($urandom);
      else            pb = good_pbit(m, d) ^ ($urandom_range(0, 3) == 0);
      set_mode(m);
      frame_check(d, m, pb, st, "random R6");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule